// File: doc/BRIEF.md
# Adaptive-Precision Systolic Processing Element

This block is one cell of a weight-stationary systolic array. It holds a stationary weight word and multiplies an unsigned 8-bit activation by it. The weight word is read in one of three ways, chosen at runtime: one 8-bit weight, two 4-bit weights, or four 2-bit weights. The element has one pool of sixteen 2-bit by 2-bit digit multipliers and no other multiply resource. A 2-bit precision select regroups that pool, so each cycle yields one, two or four products, and peak throughput doubles at each narrower step.

Each product's digit partial products are shifted and summed in groups that the precision select chooses. The results go into up to four 24-bit accumulator lanes, which are presented to the neighbour below as partial sums. The activation and its valid bit are registered and passed on to the right-hand neighbour. The weight word is loaded through a strobe that takes effect only while no computation is in progress.

Top module: `aps_pe`

## Requirements
- R1: After reset, every accumulator lane, the forwarded activation, the forwarded valid and the stationary weight are zero. With no weight ever loaded, valid cycles leave every lane at zero.
- R2: With mode 2'b00 (full 8-bit weight), a valid cycle adds act*W[7:0] to lane 0 on the next clock edge. Lanes 1 to 3 stay unchanged.
- R3: With mode 2'b01 (two 4-bit weights), a valid cycle adds act*W[3:0] to lane 0 and act*W[7:4] to lane 1. Lanes 2 and 3 stay unchanged.
- R4: With mode 2'b10 (four 2-bit weights), a valid cycle adds act*W[2k+1:2k] to lane k for every k from 0 to 3.
- R5: Mode 2'b11 is reserved and behaves exactly as mode 2'b00.
- R6: When clear is high, every lane reads zero after the next edge. Clear takes priority over a valid cycle in the same clock.
- R7: With valid and clear both low, every lane holds its value, whatever the activation and mode inputs do.
- R8: The weight strobe latches the weight input only when valid is low. A strobe during a valid cycle is ignored, and that cycle's products use the weight held before it.
- R9: act_o and act_valid_o equal act_i and act_valid_i delayed by exactly one clock.
- R10: Lanes are 24 bits wide and wrap modulo 2^24 on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Precision select: 00 one 8-bit, 01 two 4-bit, 10 four 2-bit, 11 as 00 |
| act_i | input | 8 | Unsigned activation from the left neighbour |
| act_valid_i | input | 1 | Activation is valid, so accumulate this cycle |
| wload_i | input | 1 | Weight load strobe |
| wdata_i | input | 8 | Weight word to latch |
| clear_i | input | 1 | Zero all accumulator lanes |
| act_o | output | 8 | Registered activation to the right neighbour |
| act_valid_o | output | 1 | Registered valid to the right neighbour |
| psum_o | output | 96 | Accumulator lanes; lane k sits at bits [24k+23:24k] |

## Verification
Two situations are hard to reach from the ports. The first is a lane wrapping past 2^24: it needs hundreds of back-to-back full-scale products. The stimulus loads weight 0xFF and streams activation 0xFF in 8-bit mode for 300 cycles. The second is a weight strobe that coincides with a valid cycle. The bench raises both together, then computes in 2-bit mode with a weight whose digits are all different, so a wrongly taken load changes every lane. Mode changes without an intervening clear are driven from a pseudo-random sequence, which shows that lanes unused by the current mode keep their earlier totals.

// File: rtl/aps_pkg.sv
package aps_pkg;

    typedef enum logic [1:0] {
        PM_W8 = 2'b00,
        PM_W4 = 2'b01,
        PM_W2 = 2'b10
    } prec_mode_e;

    // map the raw select onto a mode; the reserved code falls back to full width
    function automatic prec_mode_e decode_mode(input logic [1:0] raw);
        prec_mode_e m;
        unique case (raw)
            2'b01:   m = PM_W4;
            2'b10:   m = PM_W2;
            default: m = PM_W8;
        endcase
        return m;
    endfunction

    // log2 of the number of weight digits that form one product
    function automatic int group_log2(input prec_mode_e m, input int digs);
        int r;
        unique case (m)
            PM_W4:   r = $clog2(digs) - 1;
            PM_W2:   r = 0;
            default: r = $clog2(digs);
        endcase
        return r;
    endfunction

    // number of accumulator lanes that a mode drives
    function automatic int lanes_used(input prec_mode_e m, input int digs);
        return digs >> group_log2(m, digs);
    endfunction

endpackage

// File: rtl/aps_digit_array.sv
module aps_digit_array #(
    parameter int DIG_W = 2,
    parameter int DIGS  = 4,
    localparam int OP_W = DIG_W * DIGS,
    localparam int PW   = 2 * DIG_W,
    localparam int NMUL = DIGS * DIGS
) (
    input  logic [OP_W-1:0]      act_i,
    input  logic [OP_W-1:0]      wgt_i,
    output logic [NMUL*PW-1:0]   prod_o
);

    // one small multiplier per (activation digit, weight digit) pair
    for (genvar i = 0; i < DIGS; i++) begin : g_act
        for (genvar j = 0; j < DIGS; j++) begin : g_wgt
            logic [PW-1:0] a_ext, w_ext;
            assign a_ext = PW'(act_i[i*DIG_W +: DIG_W]);
            assign w_ext = PW'(wgt_i[j*DIG_W +: DIG_W]);
            assign prod_o[(i*DIGS+j)*PW +: PW] = a_ext * w_ext;
        end
    end

endmodule

// File: rtl/aps_reduce.sv
module aps_reduce
    import aps_pkg::*;
#(
    parameter int DIG_W = 2,
    parameter int DIGS  = 4,
    localparam int PW    = 2 * DIG_W,
    localparam int NMUL  = DIGS * DIGS,
    localparam int SUM_W = 2 * DIG_W * DIGS,
    localparam int LW    = (DIGS > 1) ? $clog2(DIGS) : 1
) (
    input  prec_mode_e              mode_i,
    input  logic [NMUL*PW-1:0]      prod_i,
    output logic [DIGS*SUM_W-1:0]   sum_o
);

    logic [SUM_W-1:0] sums [DIGS];

    // weight digit j goes to lane j>>g, shifted by its place inside the group
    always_comb begin
        int g;
        int msk;
        int jl;
        logic [LW-1:0] lane;
        g   = group_log2(mode_i, DIGS);
        msk = (1 << g) - 1;
        for (int k = 0; k < DIGS; k++) sums[k] = '0;
        for (int j = 0; j < DIGS; j++) begin
            lane = LW'(j >> g);
            jl   = j & msk;
            for (int i = 0; i < DIGS; i++) begin
                sums[lane] = sums[lane] +
                    (SUM_W'(prod_i[(i*DIGS+j)*PW +: PW]) << (DIG_W*(i+jl)));
            end
        end
    end

    for (genvar k = 0; k < DIGS; k++) begin : g_out
        assign sum_o[k*SUM_W +: SUM_W] = sums[k];
    end

endmodule

// File: rtl/aps_acc_lanes.sv
module aps_acc_lanes
    import aps_pkg::*;
#(
    parameter int LANES = 4,
    parameter int SUM_W = 16,
    parameter int ACC_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     valid_i,
    input  prec_mode_e               mode_i,
    input  logic [LANES*SUM_W-1:0]   sum_i,
    output logic [LANES*ACC_W-1:0]   acc_o
);

    logic [ACC_W-1:0] acc_q [LANES];
    int               n_act;

    assign n_act = lanes_used(mode_i, LANES);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[k] <= '0;
            end else if (clear_i) begin
                acc_q[k] <= '0;
            end else if (valid_i && (k < n_act)) begin
                acc_q[k] <= acc_q[k] + ACC_W'(sum_i[k*SUM_W +: SUM_W]);
            end
        end
        assign acc_o[k*ACC_W +: ACC_W] = acc_q[k];
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (acc_o == '0)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !valid_i) |=> $stable(acc_o)); // R7
    AST_W8_SPARE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && mode_i == PM_W8) |=> $stable(acc_o[LANES*ACC_W-1:ACC_W])); // R2

endmodule

// File: rtl/aps_pe.sv
module aps_pe
    import aps_pkg::*;
#(
    parameter int DIG_W = 2,
    parameter int DIGS  = 4,
    parameter int ACC_W = 24,
    localparam int OP_W  = DIG_W * DIGS,
    localparam int PW    = 2 * DIG_W,
    localparam int NMUL  = DIGS * DIGS,
    localparam int SUM_W = 2 * OP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode_i,
    input  logic [OP_W-1:0]         act_i,
    input  logic                    act_valid_i,
    input  logic                    wload_i,
    input  logic [OP_W-1:0]         wdata_i,
    input  logic                    clear_i,
    output logic [OP_W-1:0]         act_o,
    output logic                    act_valid_o,
    output logic [DIGS*ACC_W-1:0]   psum_o
);

    prec_mode_e          mode_eff;
    logic [OP_W-1:0]     w_q;
    logic [OP_W-1:0]     act_q;
    logic                vld_q;
    logic [NMUL*PW-1:0]  prod;
    logic [DIGS*SUM_W-1:0] lane_sum;

    assign mode_eff = decode_mode(mode_i);

    // stationary weight: reload only between computations
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else if (wload_i && !act_valid_i) begin
            w_q <= wdata_i;
        end
    end

    // activation pipeline toward the right neighbour
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
            vld_q <= 1'b0;
        end else begin
            act_q <= act_i;
            vld_q <= act_valid_i;
        end
    end

    assign act_o       = act_q;
    assign act_valid_o = vld_q;

    aps_digit_array #(.DIG_W(DIG_W), .DIGS(DIGS)) u_digits (
        .act_i (act_i),
        .wgt_i (w_q),
        .prod_o(prod)
    );

    aps_reduce #(.DIG_W(DIG_W), .DIGS(DIGS)) u_reduce (
        .mode_i(mode_eff),
        .prod_i(prod),
        .sum_o (lane_sum)
    );

    aps_acc_lanes #(.LANES(DIGS), .SUM_W(SUM_W), .ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(clear_i),
        .valid_i(act_valid_i),
        .mode_i (mode_eff),
        .sum_i  (lane_sum),
        .acc_o  (psum_o)
    );

    AST_WEIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid_i |=> $stable(w_q)); // R8
    AST_ACT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (act_o == $past(act_i) && act_valid_o == $past(act_valid_i))); // R9
    AST_RSV_AS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11 && act_valid_i && !clear_i) |=> $stable(psum_o[DIGS*ACC_W-1:ACC_W])); // R5

endmodule

// File: tb/aps_pe_bench.sv
module aps_pe_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  act = '0;
    logic        vld = 1'b0;
    logic        wload = 1'b0;
    logic [7:0]  wdata = '0;
    logic        clr = 1'b0;
    logic [7:0]  act_o;
    logic        vld_o;
    logic [95:0] psum;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference state
    int unsigned m_lane [4];
    int unsigned m_w    = 0;
    int unsigned m_act  = 0;
    int unsigned m_vld  = 0;

    always #5 clk = ~clk;

    aps_pe u_aps_pe (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .act_i(act),
        .act_valid_i(vld), .wload_i(wload), .wdata_i(wdata), .clear_i(clr),
        .act_o(act_o), .act_valid_o(vld_o), .psum_o(psum)
    );

    task automatic chk(input string tag, input string what,
                       input int unsigned got, input int unsigned exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk("R9", "act_o", act_o, m_act);
        chk("R9", "act_valid_o", vld_o, m_vld);
        for (int k = 0; k < 4; k++)
            chk(tag, $sformatf("lane%0d", k), psum[k*24 +: 24], m_lane[k]);
    endtask

    // apply current inputs for one clock, update the model, check at negedge
    task automatic cyc(input string tag);
        @(posedge clk);
        if (clr) begin
            for (int k = 0; k < 4; k++) m_lane[k] = 0;
        end else if (vld) begin
            if (mode == 2'b01) begin
                m_lane[0] = (m_lane[0] + act * (m_w & 15)) & 24'hFFFFFF;
                m_lane[1] = (m_lane[1] + act * ((m_w >> 4) & 15)) & 24'hFFFFFF;
            end else if (mode == 2'b10) begin
                for (int k = 0; k < 4; k++)
                    m_lane[k] = (m_lane[k] + act * ((m_w >> (2*k)) & 3)) & 24'hFFFFFF;
            end else begin
                m_lane[0] = (m_lane[0] + act * m_w) & 24'hFFFFFF;
            end
        end
        if (wload && !vld) m_w = wdata;
        m_act = act;
        m_vld = vld;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic load_w(input logic [7:0] w);
        wload = 1'b1; wdata = w; vld = 1'b0; clr = 1'b0;
        cyc("R8");
        wload = 1'b0;
    endtask

    task automatic run(input logic [1:0] md, input logic [7:0] a, input string tag);
        mode = md; act = a; vld = 1'b1; clr = 1'b0;
        cyc(tag);
        vld = 1'b0;
    endtask

    task automatic clear_all();
        clr = 1'b1; vld = 1'b0;
        cyc("R6");
        clr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        for (int k = 0; k < 4; k++) m_lane[k] = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;

        // R1: weight is zero after reset, so products vanish
        run(2'b00, 8'hFF, "R1");
        run(2'b10, 8'hAB, "R1");

        // R2: full-width products into lane 0
        load_w(8'hB7);
        run(2'b00, 8'h01, "R2");
        run(2'b00, 8'hFF, "R2");
        run(2'b00, 8'h5A, "R2");

        // R6: clear, and clear beating valid
        clear_all();
        run(2'b00, 8'h33, "R2");
        clr = 1'b1; vld = 1'b1; act = 8'hFF; cyc("R6"); clr = 1'b0; vld = 1'b0;

        // R3: two nibble weights
        load_w(8'h5C);
        run(2'b01, 8'hFF, "R3");
        run(2'b01, 8'h81, "R3");
        run(2'b01, 8'h07, "R3");

        // R4: four 2-bit weights with distinct digits
        load_w(8'hE4);
        run(2'b10, 8'hFF, "R4");
        run(2'b10, 8'h3C, "R4");

        // R5: reserved code acts as full width
        run(2'b11, 8'h9D, "R5");
        run(2'b11, 8'hFF, "R5");

        // R7: idle inputs wander, lanes hold
        for (int t = 0; t < 6; t++) begin
            mode = 2'(t); act = 8'(t * 41 + 3); vld = 1'b0; clr = 1'b0;
            cyc("R7");
        end

        // R8: strobe during a valid cycle is ignored
        mode = 2'b10; act = 8'hC3; vld = 1'b1; wload = 1'b1; wdata = 8'h01;
        cyc("R8");
        wload = 1'b0;
        run(2'b10, 8'hFF, "R8");
        run(2'b00, 8'h11, "R8");

        // R10: wrap of lane 0
        clear_all();
        load_w(8'hFF);
        for (int t = 0; t < 300; t++) run(2'b00, 8'hFF, "R10");

        // mixed modes without clearing
        lcg = 32'h1234_5678;
        for (int t = 0; t < 80; t++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            if (lcg[3:0] == 4'h0) load_w(lcg[23:16]);
            else run(lcg[9:8], lcg[31:24], "R4");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule